// File: doc/BRIEF.md
# Accumulating Eight-Bit Function Datapath

This block is a clocked execution slice for a small processor. On each clock edge it captures two data operands, a four-bit function code, a carry input and a feedback select. A read-enable gate sits after these capture registers. While it is low, the function logic sees zeros in place of the captured values. The gated values drive five function units: bitwise logic, ripple add/subtract, invert/pass, single-bit shift through carry, and fixed odd-amount left rotation.

Exactly one unit owns each function code. The other units are masked to zero before the outputs are merged. On the next edge the merged value is written into the result register. The carry output is combinational from the captured operands. It is meaningful only for the arithmetic and shift codes.

The result register can stand in for the first operand, so a chain of operations accumulates without the host reloading data. It has its own asynchronous reset. Clearing the operand side leaves a stored result untouched, and clearing the result leaves the captured operands intact.

Top module: `fbk_alu_core`

## Requirements
- R1: While `res_rst` is high, `res_out` is 0. While both resets are high, `cout` is 0.
- R2: Codes 0 to 5 (0000 AND, 0001 NAND, 0010 NOR, 0011 OR, 0100 XOR, 0101 XNOR) yield the bitwise function of operands X and Y, with `cout` 0.
- R3: Code 0111 yields X+Y, with `cout` as the carry from bit 7. Code 0110 yields X+~Y+1, with `cout` as that carry (1 when X ≥ Y unsigned).
- R4: Code 1000 yields ~X and code 1001 yields X. Both give `cout` 0.
- R5: Code 1010 shifts X right by one. The captured carry-in enters bit 7, and `cout` is the old bit 0.
- R6: Code 1011 shifts X left by one. The captured carry-in enters bit 0, and `cout` is the old bit 7.
- R7: Codes 1100, 1101, 1110 and 1111 rotate X left by 1, 3, 5 and 7 places, with `cout` 0.
- R8: Inputs are captured on a rising edge. `cout` reflects them after that edge, and `res_out` takes the function of them on the following edge.
- R9: While `rd_en` is low, the captured operands, code and carry-in are seen as 0. The function is then AND of zeros, giving result 0 and `cout` 0.
- R10: With the captured `fb_sel` at 1, X is the current `res_out` and not the captured `a_in`. Y is always the captured `b_in`.
- R11: Pulsing `opnd_rst` leaves `res_out` unchanged. Pulsing `res_rst` leaves the captured operands unchanged, which is seen on `cout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| opnd_rst | input | 1 | Async active-high clear of operand, code, carry-in and select registers |
| res_rst | input | 1 | Async active-high clear of the result register |
| rd_en | input | 1 | Read gate on the captured operand, code and carry-in |
| fb_sel | input | 1 | 1 selects the result register as operand X (captured) |
| cin | input | 1 | Carry-in for shifts (captured) |
| a_in | input | DW | Operand A |
| b_in | input | DW | Operand B |
| op_in | input | 4 | Function code |
| res_out | output | DW | Result register |
| cout | output | 1 | Carry out of the current function |

## Verification
The two activities that share a cycle are the write of the result register and the read of that same register as operand X through the feedback path. The bench provokes this with back-to-back feedback additions and shifts. Each step there consumes the value written on the edge before it. A scoreboard model advances its own copy of the result in the same cycle order and judges every result and carry against it. A second overlap is a reset pulse landing between the edges of a running sequence. This is judged by sampling the opposite register side before the next edge.

// File: rtl/fbk_alu_pkg.sv
package fbk_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'h0, OP_NAND = 4'h1, OP_NOR  = 4'h2, OP_OR   = 4'h3,
    OP_XOR  = 4'h4, OP_XNOR = 4'h5, OP_SUB  = 4'h6, OP_ADD  = 4'h7,
    OP_NOT  = 4'h8, OP_PASS = 4'h9, OP_SHR  = 4'hA, OP_SHL  = 4'hB,
    OP_ROT1 = 4'hC, OP_ROT3 = 4'hD, OP_ROT5 = 4'hE, OP_ROT7 = 4'hF
  } op_e;

  localparam int U_LOGIC   = 0;
  localparam int U_ARITH   = 1;
  localparam int U_MOVE    = 2;
  localparam int U_SHIFT   = 3;
  localparam int U_ROT     = 4;
  localparam int NUM_UNITS = 5;
endpackage

// File: rtl/fbk_opnd_regs.sv
module fbk_opnd_regs
  import fbk_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  input  logic [OP_W-1:0] op_in,
  input  logic            cin_in,
  input  logic            fb_in,
  output logic [DW-1:0]   a_o,
  output logic [DW-1:0]   b_o,
  output logic [OP_W-1:0] op_o,
  output logic            cin_o,
  output logic            fb_o
);
  logic [DW-1:0]   a_q, b_q;
  logic [OP_W-1:0] op_q;
  logic            cin_q, fb_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      op_q  <= '0;
      cin_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      a_q   <= a_in;
      b_q   <= b_in;
      op_q  <= op_in;
      cin_q <= cin_in;
      fb_q  <= fb_in;
    end
  end

  // read gate on captured values; the feedback select is not gated
  assign a_o   = a_q & {DW{rd_en}};
  assign b_o   = b_q & {DW{rd_en}};
  assign op_o  = op_q & {OP_W{rd_en}};
  assign cin_o = cin_q & rd_en;
  assign fb_o  = fb_q;
endmodule

// File: rtl/fbk_func_units.sv
module fbk_func_units
  import fbk_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]        x_i,
  input  logic [DW-1:0]        y_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic                 cin_i,
  output logic [DW-1:0]        res_o,
  output logic                 cout_o,
  output logic [NUM_UNITS-1:0] sel_o
);
  function automatic logic [DW:0] f_ripple(input logic [DW-1:0] p, input logic [DW-1:0] q,
                                           input logic c0);
    logic          c;
    logic [DW-1:0] s;
    c = c0;
    for (int i = 0; i < DW; i++) begin
      s[i] = p[i] ^ q[i] ^ c;
      c    = (p[i] & q[i]) | (c & (p[i] ^ q[i]));
    end
    return {c, s};
  endfunction

  function automatic logic [DW-1:0] f_logic(input logic [2:0] k, input logic [DW-1:0] p,
                                            input logic [DW-1:0] q);
    case (k)
      3'd0:    return p & q;
      3'd1:    return ~(p & q);
      3'd2:    return ~(p | q);
      3'd3:    return p | q;
      3'd4:    return p ^ q;
      3'd5:    return ~(p ^ q);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_rotl(input logic [DW-1:0] p, input int amt);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = p[(i + DW - (amt % DW)) % DW];
    return r;
  endfunction

  // unit decode: one owner per code
  always_comb begin
    sel_o = '0;
    case (op_i)
      OP_AND, OP_NAND, OP_NOR, OP_OR, OP_XOR, OP_XNOR: sel_o[U_LOGIC] = 1'b1;
      OP_SUB, OP_ADD:                                  sel_o[U_ARITH] = 1'b1;
      OP_NOT, OP_PASS:                                 sel_o[U_MOVE]  = 1'b1;
      OP_SHR, OP_SHL:                                  sel_o[U_SHIFT] = 1'b1;
      default:                                         sel_o[U_ROT]   = 1'b1;
    endcase
  end

  logic [DW-1:0] uval [NUM_UNITS];
  logic          ucar [NUM_UNITS];
  logic [DW-1:0] mval [NUM_UNITS];
  logic          mcar [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (u == U_LOGIC) begin : g_logic
      assign uval[u] = f_logic(op_i[2:0], x_i, y_i);
      assign ucar[u] = 1'b0;
    end else if (u == U_ARITH) begin : g_arith
      logic [DW:0] sum;
      // bit 0 set = add, clear = subtract (invert Y, carry in 1)
      assign sum     = f_ripple(x_i, op_i[0] ? y_i : ~y_i, ~op_i[0]);
      assign uval[u] = sum[DW-1:0];
      assign ucar[u] = sum[DW];
    end else if (u == U_MOVE) begin : g_move
      assign uval[u] = op_i[0] ? x_i : ~x_i;
      assign ucar[u] = 1'b0;
    end else if (u == U_SHIFT) begin : g_shift
      assign uval[u] = op_i[0] ? {x_i[DW-2:0], cin_i} : {cin_i, x_i[DW-1:1]};
      assign ucar[u] = op_i[0] ? x_i[DW-1] : x_i[0];
    end else begin : g_rot
      int amt;
      assign amt     = 2 * int'(op_i[1:0]) + 1;
      assign uval[u] = f_rotl(x_i, amt);
      assign ucar[u] = 1'b0;
    end
    assign mval[u] = uval[u] & {DW{sel_o[u]}};
    assign mcar[u] = ucar[u] & sel_o[u];
  end

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      res_o  = res_o | mval[u];
      cout_o = cout_o | mcar[u];
    end
  end
endmodule

// File: rtl/fbk_result_reg.sv
module fbk_result_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/fbk_alu_core.sv
module fbk_alu_core
  import fbk_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            opnd_rst,
  input  logic            res_rst,
  input  logic            rd_en,
  input  logic            fb_sel,
  input  logic            cin,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  input  logic [OP_W-1:0] op_in,
  output logic [DW-1:0]   res_out,
  output logic            cout
);
  logic [DW-1:0]        a_g, b_g, a_eff, func_res, res_q;
  logic [OP_W-1:0]      op_g;
  logic                 cin_g, fb_q;
  logic [NUM_UNITS-1:0] unit_sel;

  fbk_opnd_regs #(.DW(DW)) u_opnd (
    .clk(clk), .rst(opnd_rst), .rd_en(rd_en),
    .a_in(a_in), .b_in(b_in), .op_in(op_in), .cin_in(cin), .fb_in(fb_sel),
    .a_o(a_g), .b_o(b_g), .op_o(op_g), .cin_o(cin_g), .fb_o(fb_q)
  );

  assign a_eff = fb_q ? res_q : a_g;

  fbk_func_units #(.DW(DW)) u_func (
    .x_i(a_eff), .y_i(b_g), .op_i(op_g), .cin_i(cin_g),
    .res_o(func_res), .cout_o(cout), .sel_o(unit_sel)
  );

  fbk_result_reg #(.DW(DW)) u_res (
    .clk(clk), .rst(res_rst), .d_i(func_res), .q_o(res_q)
  );

  assign res_out = res_q;
endmodule

// File: rtl/fbk_alu_checker.sv
module fbk_alu_checker
  import fbk_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 opnd_rst,
  input logic                 res_rst,
  input logic                 rd_en,
  input logic [DW-1:0]        res_out,
  input logic                 cout,
  input logic [OP_W-1:0]      op_g,
  input logic [DW-1:0]        a_eff,
  input logic [DW-1:0]        func_res,
  input logic [NUM_UNITS-1:0] unit_sel,
  input logic                 fb_q
);
  // set by any reset, cleared by the next clean edge
  logic hit;
  always_ff @(posedge clk or posedge opnd_rst or posedge res_rst) begin
    if (opnd_rst || res_rst) hit <= 1'b1;
    else                     hit <= 1'b0;
  end

  AST_ONE_UNIT: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    $countones(unit_sel) == 1); // R2
  AST_SHR_CARRY: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    op_g == OP_SHR |-> cout == a_eff[0]); // R5
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    op_g == OP_SHL |-> cout == a_eff[DW-1]); // R6
  AST_ROT_NO_CARRY: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    op_g[3:2] == 2'b11 |-> !cout); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    !hit |-> res_out == $past(func_res)); // R8
  AST_GATED_ZERO: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    (!rd_en && !fb_q) |-> (func_res == '0 && !cout)); // R9
  AST_FB_PASS: assert property (@(posedge clk) disable iff (opnd_rst || res_rst)
    (fb_q && op_g == OP_PASS) |-> func_res == res_out); // R10
endmodule

bind fbk_alu_core fbk_alu_checker #(.DW(DW)) u_chk (
  .clk(clk), .opnd_rst(opnd_rst), .res_rst(res_rst), .rd_en(rd_en),
  .res_out(res_out), .cout(cout), .op_g(op_g), .a_eff(a_eff),
  .func_res(func_res), .unit_sel(unit_sel), .fb_q(fb_q)
);

// File: tb/fbk_alu_core_bench.sv
`timescale 1ns/1ps
module fbk_alu_core_bench;
  logic       clk = 1'b0;
  logic       opnd_rst, res_rst, rd_en, fb_sel, cin;
  logic [7:0] a_in, b_in, res_out;
  logic [3:0] op_in;
  logic       cout;

  int total = 0;
  int bad   = 0;

  logic [8:0] exp_q[$];
  string      rtag_q[$];
  string      ctag_q[$];

  // model of the captured operand side and the result register
  logic [7:0] pa, pb, m_res;
  logic [3:0] pop;
  logic       pci, pfb;
  string      ptag;

  always #5 clk = ~clk;

  fbk_alu_core u_fbk_alu_core (
    .clk(clk), .opnd_rst(opnd_rst), .res_rst(res_rst), .rd_en(rd_en),
    .fb_sel(fb_sel), .cin(cin), .a_in(a_in), .b_in(b_in), .op_in(op_in),
    .res_out(res_out), .cout(cout)
  );

  // returns {carry, value}
  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] op, input logic ci, input logic fb,
                                       input logic rd, input logic [7:0] r);
    logic [7:0] x, y, v;
    int k;
    if (!rd) begin a = 8'h00; b = 8'h00; op = 4'h0; ci = 1'b0; end
    x = fb ? r : a;
    y = b;
    case (op)
      4'h0: return {1'b0, x & y};
      4'h1: return {1'b0, ~(x & y)};
      4'h2: return {1'b0, ~(x | y)};
      4'h3: return {1'b0, x | y};
      4'h4: return {1'b0, x ^ y};
      4'h5: return {1'b0, ~(x ^ y)};
      4'h6: return {(x >= y), x - y};
      4'h7: return {1'b0, x} + {1'b0, y};
      4'h8: return {1'b0, ~x};
      4'h9: return {1'b0, x};
      4'hA: return {x[0], ci, x[7:1]};
      4'hB: return {x[7], x[6:0], ci};
      default: begin
        k = 2 * (int'(op) - 12) + 1;
        v = (x << k) | (x >> (8 - k));
        return {1'b0, v};
      end
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push_item(input string tag);
    logic [8:0] c;
    c = model(pa, pb, pop, pci, pfb, rd_en, m_res);
    exp_q.push_back({c[8], m_res});
    rtag_q.push_back(ptag);
    ctag_q.push_back(tag);
    ptag = tag;
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op,
                      input logic ci, input logic fb, input logic rd, input string tag);
    logic [8:0] r;
    @(negedge clk);
    #2;
    a_in = a; b_in = b; op_in = op; cin = ci; fb_sel = fb; rd_en = rd;
    @(posedge clk);
    r = model(pa, pb, pop, pci, pfb, rd_en, m_res);
    m_res = r[7:0];
    pa = a; pb = b; pop = op; pci = ci; pfb = fb;
    push_item(tag);
  endtask

  // R11: operand-side reset pulse between edges
  task automatic pulse_opnd;
    logic [8:0] r;
    @(negedge clk);
    #3 opnd_rst = 1'b1;
    #1;
    chk("R11 result kept on operand reset", res_out, m_res);
    chk("R1 carry with cleared operands", cout, 0);
    opnd_rst = 1'b0;
    @(posedge clk);
    r = model(8'h00, 8'h00, 4'h0, 1'b0, 1'b0, rd_en, m_res);
    m_res = r[7:0];
    pa = a_in; pb = b_in; pop = op_in; pci = cin; pfb = fb_sel;
    push_item("R11");
  endtask

  // R11: result-side reset pulse between edges
  task automatic pulse_res;
    logic [8:0] r;
    @(negedge clk);
    #3 res_rst = 1'b1;
    #1;
    chk("R1 result cleared", res_out, 0);
    r = model(pa, pb, pop, pci, pfb, rd_en, 8'h00);
    chk("R11 operands kept on result reset", cout, r[8]);
    res_rst = 1'b0;
    m_res = 8'h00;
    @(posedge clk);
    r = model(pa, pb, pop, pci, pfb, rd_en, m_res);
    m_res = r[7:0];
    pa = a_in; pb = b_in; pop = op_in; pci = cin; pfb = fb_sel;
    push_item("R11");
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    logic [8:0] e;
    string rt, ct;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        rt = rtag_q.pop_front();
        ct = ctag_q.pop_front();
        chk({rt, " result"}, res_out, e[7:0]);
        chk({ct, " carry"}, cout, e[8]);
      end
    end
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pat_a [3];
    logic [7:0] pat_b [3];
    pat_a[0] = 8'hA5; pat_b[0] = 8'h3C;
    pat_a[1] = 8'hFF; pat_b[1] = 8'h00;
    pat_a[2] = 8'h0F; pat_b[2] = 8'h0F;

    opnd_rst = 1'b1; res_rst = 1'b1; rd_en = 1'b1; fb_sel = 1'b0; cin = 1'b0;
    a_in = 8'h00; b_in = 8'h00; op_in = 4'h0;
    pa = 8'h00; pb = 8'h00; pop = 4'h0; pci = 1'b0; pfb = 1'b0; m_res = 8'h00; ptag = "R1";
    #1;
    chk("R1 reset result", res_out, 0);
    chk("R1 reset carry", cout, 0);
    repeat (3) @(negedge clk);
    #1 opnd_rst = 1'b0; res_rst = 1'b0;

    // R2 logic codes
    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 6; o++)
        step(pat_a[p], pat_b[p], 4'(o), 1'b1, 1'b0, 1'b1, "R2");

    // R3 add and subtract, carry boundaries
    step(8'h7F, 8'h01, 4'h7, 1'b0, 1'b0, 1'b1, "R3");
    step(8'hFF, 8'h01, 4'h7, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h05, 8'h03, 4'h6, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h03, 8'h05, 4'h6, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h00, 8'h00, 4'h6, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h80, 8'h01, 4'h6, 1'b1, 1'b0, 1'b1, "R3");

    // R4 invert and pass, carry-in set
    step(8'h5A, 8'hFF, 4'h8, 1'b1, 1'b0, 1'b1, "R4");
    step(8'hC3, 8'hFF, 4'h9, 1'b1, 1'b0, 1'b1, "R4");

    // R5 and R6 shifts through carry
    step(8'h81, 8'h00, 4'hA, 1'b1, 1'b0, 1'b1, "R5");
    step(8'h02, 8'h00, 4'hA, 1'b0, 1'b0, 1'b1, "R5");
    step(8'h81, 8'h00, 4'hB, 1'b0, 1'b0, 1'b1, "R6");
    step(8'h40, 8'h00, 4'hB, 1'b1, 1'b0, 1'b1, "R6");

    // R7 rotates
    for (int o = 12; o < 16; o++) step(8'h81, 8'h00, 4'(o), 1'b1, 1'b0, 1'b1, "R7");
    for (int o = 12; o < 16; o++) step(8'h96, 8'h00, 4'(o), 1'b0, 1'b0, 1'b1, "R7");

    // R8 back-to-back mixed stream
    for (int i = 0; i < 40; i++)
      step(8'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'b0, 1'b1, "R8");

    // R9 read gate low
    step(8'hFF, 8'h01, 4'h7, 1'b1, 1'b0, 1'b0, "R9");
    step(8'h3C, 8'hC3, 4'h3, 1'b1, 1'b0, 1'b0, "R9");
    step(8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 1'b1, "R9");

    // R10 feedback accumulation and chained shifts
    step(8'h01, 8'h00, 4'h9, 1'b0, 1'b0, 1'b1, "R10");
    for (int i = 0; i < 4; i++) step(8'hEE, 8'h03, 4'h7, 1'b0, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 3; i++) step(8'h00, 8'h00, 4'hB, 1'b1, 1'b1, 1'b1, "R10");
    step(8'h55, 8'h00, 4'h9, 1'b0, 1'b1, 1'b1, "R10");
    step(8'h55, 8'h00, 4'hD, 1'b0, 1'b1, 1'b1, "R10");

    // R11 independent resets
    step(8'hF0, 8'h20, 4'h7, 1'b0, 1'b0, 1'b1, "R11");
    step(8'hF0, 8'h20, 4'h7, 1'b0, 1'b0, 1'b1, "R11");
    pulse_res;
    step(8'h3A, 8'h00, 4'h9, 1'b0, 1'b0, 1'b1, "R11");
    step(8'h3A, 8'h00, 4'h9, 1'b0, 1'b0, 1'b1, "R11");
    pulse_opnd;
    step(8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 1'b1, "R8");
    step(8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 1'b1, "R8");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule